// File: doc/BRIEF.md
# Load/Store Cache Port Arbiter

This block decides, cycle by cycle, which of two requesters may use a single data-cache port: the incoming load stream or the oldest entry of the store queue. The port feeds a two-stage cache pipeline. Loads and stores can each issue on consecutive cycles. A load can never issue in the cycle directly after a store. Loads normally have priority, so a store may wait a long time without harm. When the store queue is full, or when a store is holding up the pipeline, the store takes priority and is guaranteed to issue.

The grant outputs are combinational from the request inputs and one registered bit of history. The block also tracks which operation is in each of the two pipeline stages. It keeps a small saturating count of how many times the waiting store has lost to a load. The cache array, the queue storage and the address comparison sit outside this block.

Top module: `lsq_port_arb`

## Requirements
- R1: At most one of `ld_gnt` and `st_gnt` is high in any cycle, and `port_issue` equals their OR.
- R2: A grant goes only to a requester whose request input is high in that cycle. With no request, no grant is given, whatever the state of `sq_full` and `st_stall`.
- R3: When neither `sq_full` nor `st_stall` is high and no store was granted in the previous cycle, a requesting load is granted even if a store is also requesting.
- R4: While `sq_full` is high, a requesting store is granted in that cycle, including over a requesting load.
- R5: While `st_stall` is high, a requesting store is granted in that cycle, including over a requesting load.
- R6: In the cycle directly after a store grant, `ld_gnt` stays low.
- R7: In the cycle directly after a store grant, a requesting store is granted even without raised priority.
- R8: Loads can be granted on consecutive cycles, and stores can be granted on consecutive cycles.
- R9: `s1_vld`/`s1_st` show the grant of the previous cycle, and `s2_vld`/`s2_st` show the grant of two cycles earlier. The `_st` bit is 1 for a store and 0 for a load or an empty stage.
- R10: `st_wait` rises by one in the cycle after a requesting store loses to a load, and it saturates at all ones. It reads zero in the cycle after any store grant and holds its value otherwise.
- R11: While `rst` is high no grant is given. After a reset cycle, both stage outputs and `st_wait` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | A load wants the port this cycle |
| st_req | input | 1 | The store-queue head wants the port this cycle |
| sq_full | input | 1 | The store queue is full, so the store gets priority |
| st_stall | input | 1 | A store is stalling the pipeline, so the store gets priority |
| ld_gnt | output | 1 | The load is granted the port |
| st_gnt | output | 1 | The store is granted the port |
| port_issue | output | 1 | An access enters the cache pipeline this cycle |
| s1_vld | output | 1 | Pipeline stage 1 holds an access |
| s1_st | output | 1 | The access in stage 1 is a store |
| s2_vld | output | 1 | Pipeline stage 2 holds an access |
| s2_st | output | 1 | The access in stage 2 is a store |
| st_wait | output | LOSS_W | Saturating count of losses by the waiting store |

## Verification
Two rules can meet in one cycle: the bubble after a store, which blocks the load, and raised store priority. The bench also sets up the case where the bubble and an ordinary load-versus-store contest fall together. It does this by following a store grant with both requests high, first with priority raised and then without. In both cases the store must be granted again and the load held off. The bench judges this from the grant pins and from the stage outputs on the next two cycles. The loss counter is driven into saturation and then cleared by a store grant, to show the two conditions that affect it.

// File: rtl/lsq_port_arb_pkg.sv
package lsq_port_arb_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } port_op_e;

    typedef struct packed {
        logic     vld;
        port_op_e op;
    } pipe_slot_t;

    localparam pipe_slot_t SLOT_EMPTY = '{vld: 1'b0, op: OP_LOAD};

    function automatic logic store_boosted(input logic full, input logic stall);
        return full | stall;
    endfunction

    function automatic pipe_slot_t make_slot(input logic ld_g, input logic st_g);
        pipe_slot_t s;
        s.vld = ld_g | st_g;
        s.op  = st_g ? OP_STORE : OP_LOAD;
        return s;
    endfunction

endpackage

// File: rtl/lsq_arb_pick.sv
module lsq_arb_pick
    import lsq_port_arb_pkg::*;
(
    input  logic en,
    input  logic ld_req,
    input  logic st_req,
    input  logic sq_full,
    input  logic st_stall,
    input  logic after_store,
    output logic ld_gnt,
    output logic st_gnt
);
    logic boost;
    logic ld_ok;

    always_comb begin
        boost  = store_boosted(sq_full, st_stall);
        ld_ok  = ld_req & ~after_store;
        ld_gnt = 1'b0;
        st_gnt = 1'b0;
        if (en) begin
            if (st_req && boost) begin
                st_gnt = 1'b1;
            end else if (ld_ok) begin
                ld_gnt = 1'b1;
            end else if (st_req) begin
                st_gnt = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsq_arb_pipe.sv
module lsq_arb_pipe
    import lsq_port_arb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  pipe_slot_t in_slot,
    output pipe_slot_t stage [STAGES]
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[g] <= SLOT_EMPTY;
            end else if (g == 0) begin
                stage[g] <= in_slot;
            end else begin
                stage[g] <= stage[(g == 0) ? 0 : g - 1];
            end
        end
    end
endmodule

// File: rtl/lsq_arb_loss.sv
module lsq_arb_loss #(
    parameter int LOSS_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lost,
    input  logic              won,
    output logic [LOSS_W-1:0] count
);
    localparam logic [LOSS_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || won) begin
            count <= '0;
        end else if (lost && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/lsq_port_arb.sv
module lsq_port_arb
    import lsq_port_arb_pkg::*;
#(
    parameter int LOSS_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_req,
    input  logic              st_req,
    input  logic              sq_full,
    input  logic              st_stall,
    output logic              ld_gnt,
    output logic              st_gnt,
    output logic              port_issue,
    output logic              s1_vld,
    output logic              s1_st,
    output logic              s2_vld,
    output logic              s2_st,
    output logic [LOSS_W-1:0] st_wait
);
    localparam int PIPE_DEPTH = 2;

    pipe_slot_t stage [PIPE_DEPTH];
    pipe_slot_t issue_slot;
    logic       after_store;

    assign after_store = stage[0].vld && (stage[0].op == OP_STORE);

    lsq_arb_pick u_pick (
        .en          (~rst),
        .ld_req      (ld_req),
        .st_req      (st_req),
        .sq_full     (sq_full),
        .st_stall    (st_stall),
        .after_store (after_store),
        .ld_gnt      (ld_gnt),
        .st_gnt      (st_gnt)
    );

    assign issue_slot = make_slot(ld_gnt, st_gnt);
    assign port_issue = issue_slot.vld;

    lsq_arb_pipe #(.STAGES(PIPE_DEPTH)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_slot (issue_slot),
        .stage   (stage)
    );

    assign s1_vld = stage[0].vld;
    assign s1_st  = stage[0].vld && (stage[0].op == OP_STORE);
    assign s2_vld = stage[1].vld;
    assign s2_st  = stage[1].vld && (stage[1].op == OP_STORE);

    lsq_arb_loss #(.LOSS_W(LOSS_W)) u_loss (
        .clk   (clk),
        .rst   (rst),
        .lost  (st_req & ld_gnt),
        .won   (st_gnt),
        .count (st_wait)
    );
endmodule

// File: rtl/lsq_port_arb_chk.sv
module lsq_port_arb_chk #(
    parameter int LOSS_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_req,
    input logic              st_req,
    input logic              sq_full,
    input logic              st_stall,
    input logic              ld_gnt,
    input logic              st_gnt,
    input logic              port_issue,
    input logic              s1_vld,
    input logic              s1_st,
    input logic              s2_vld,
    input logic              s2_st,
    input logic [LOSS_W-1:0] st_wait
);
    localparam logic [LOSS_W-1:0] WAIT_MAX = '1;

    a_r1_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_gnt, st_gnt}) && (port_issue == (ld_gnt | st_gnt)));

    a_r2_valid_ld: assert property (@(posedge clk) disable iff (rst)
        ld_gnt |-> ld_req);

    a_r2_valid_st: assert property (@(posedge clk) disable iff (rst)
        st_gnt |-> st_req);

    a_r3_load_default: assert property (@(posedge clk) disable iff (rst)
        (ld_req && !sq_full && !st_stall && !s1_st) |-> ld_gnt);

    a_r4_full_boost: assert property (@(posedge clk) disable iff (rst)
        (st_req && sq_full) |-> st_gnt);

    a_r5_stall_boost: assert property (@(posedge clk) disable iff (rst)
        (st_req && st_stall) |-> st_gnt);

    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        st_gnt |=> !ld_gnt);

    a_r7_bubble_store: assert property (@(posedge clk) disable iff (rst)
        st_gnt ##1 st_req |-> st_gnt);

    a_r9_stage1: assert property (@(posedge clk) disable iff (rst)
        port_issue |=> (s1_vld && (s1_st == $past(st_gnt))));

    a_r9_stage2: assert property (@(posedge clk) disable iff (rst)
        s1_vld |=> (s2_vld && (s2_st == $past(s1_st))));

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        st_gnt |=> (st_wait == '0));

    a_r10_count: assert property (@(posedge clk) disable iff (rst)
        (st_req && ld_gnt && st_wait != WAIT_MAX) |=>
            (st_wait == LOSS_W'($past(st_wait) + 1'b1)));

    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |-> (!ld_gnt && !st_gnt));
endmodule

bind lsq_port_arb lsq_port_arb_chk #(.LOSS_W(LOSS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ld_req     (ld_req),
    .st_req     (st_req),
    .sq_full    (sq_full),
    .st_stall   (st_stall),
    .ld_gnt     (ld_gnt),
    .st_gnt     (st_gnt),
    .port_issue (port_issue),
    .s1_vld     (s1_vld),
    .s1_st      (s1_st),
    .s2_vld     (s2_vld),
    .s2_st      (s2_st),
    .st_wait    (st_wait)
);

// File: tb/lsq_port_arb_bench.sv
module lsq_port_arb_bench;
    localparam int LOSS_W = 3;
    localparam logic [LOSS_W-1:0] WMAX = '1;
    localparam int NVEC = 15;
    // {ld_req, st_req, sq_full, st_stall, exp_ld, exp_st}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b1000_10,  // R3 lone load
        6'b1000_10,  // R8 back-to-back loads
        6'b1100_10,  // R3 load beats store
        6'b1100_10,  // R3 again, R10 count 2
        6'b1110_01,  // R4 full boost
        6'b1110_01,  // R8 back-to-back stores
        6'b1100_01,  // R7 bubble store, R6
        6'b1000_00,  // R6 load blocked after store
        6'b1000_10,  // load returns
        6'b1101_01,  // R5 stall boost
        6'b0000_00,  // idle
        6'b0100_01,  // lone store
        6'b1100_01,  // R7 bubble store again
        6'b0011_00,  // R2 no requests, boost high
        6'b1010_10   // R2 full without store
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_req = 1'b0, st_req = 1'b0, sq_full = 1'b0, st_stall = 1'b0;
    logic ld_gnt, st_gnt, port_issue, s1_vld, s1_st, s2_vld, s2_st;
    logic [LOSS_W-1:0] st_wait;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic m_s1v = 1'b0, m_s1s = 1'b0, m_s2v = 1'b0, m_s2s = 1'b0;
    logic [LOSS_W-1:0] m_wait = '0;

    always #4 clk = ~clk;

    lsq_port_arb #(.LOSS_W(LOSS_W)) u_lsq_port_arb (
        .clk(clk), .rst(rst), .ld_req(ld_req), .st_req(st_req),
        .sq_full(sq_full), .st_stall(st_stall), .ld_gnt(ld_gnt),
        .st_gnt(st_gnt), .port_issue(port_issue), .s1_vld(s1_vld),
        .s1_st(s1_st), .s2_vld(s2_vld), .s2_st(s2_st), .st_wait(st_wait)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_s1v = 0; m_s1s = 0; m_s2v = 0; m_s2s = 0; m_wait = '0;
    endtask

    task automatic step(input logic l, input logic s, input logic f, input logic t,
                        input logic el, input logic es, input string tag);
        @(negedge clk);
        ld_req = l; st_req = s; sq_full = f; st_stall = t;
        #3;
        chk({tag, " ld_gnt"}, ld_gnt, el);
        chk({tag, " st_gnt"}, st_gnt, es);
        chk("R1 port_issue", port_issue, el | es);
        chk("R9 stage1", {s1_vld, s1_st}, {m_s1v, m_s1s});
        chk("R9 stage2", {s2_vld, s2_st}, {m_s2v, m_s2s});
        chk("R10 st_wait", st_wait, m_wait);
        m_s2v = m_s1v; m_s2s = m_s1s;
        m_s1v = el | es; m_s1s = es;
        if (es) m_wait = '0;
        else if (s && el && m_wait != WMAX) m_wait = m_wait + 1'b1;
    endtask

    initial begin
        // R11 during reset: requests present, no grants
        ld_req = 1; st_req = 1; sq_full = 1;
        repeat (3) @(negedge clk);
        #3;
        chk("R11 ld_gnt in reset", ld_gnt, 0);
        chk("R11 st_gnt in reset", st_gnt, 0);
        @(negedge clk);
        #3;
        chk("R11 stages after reset", {s1_vld, s2_vld, s1_st, s2_st}, 0);
        chk("R11 st_wait after reset", st_wait, 0);
        @(negedge clk);
        rst = 0; ld_req = 0; st_req = 0; sq_full = 0;
        model_reset();

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2],
                 VEC[i][1], VEC[i][0], "R3-vector");
        end

        // R10 saturation: store loses repeatedly (previous cycle was load)
        for (int i = 0; i < 9; i++) step(1, 1, 0, 0, 1, 0, "R10 lose");
        step(0, 0, 0, 0, 0, 0, "R10 hold");
        chk("R10 saturated", st_wait, WMAX);
        step(0, 1, 0, 0, 0, 1, "R10 store wins");
        step(0, 0, 0, 0, 0, 0, "R10 after clear");

        // R6/R7 with boost in the bubble cycle
        step(0, 1, 1, 0, 0, 1, "R4 store");
        step(1, 1, 0, 1, 0, 1, "R5 bubble+stall");
        step(1, 0, 0, 0, 0, 0, "R6 bubble");
        step(1, 0, 0, 0, 1, 0, "R8 load");

        // R11 mid-run reset
        @(negedge clk);
        rst = 1; ld_req = 1; st_req = 1;
        #3;
        chk("R11 ld_gnt mid reset", ld_gnt, 0);
        chk("R11 st_gnt mid reset", st_gnt, 0);
        @(negedge clk);
        #3;
        chk("R11 stages mid reset", {s1_vld, s2_vld}, 0);
        chk("R11 st_wait mid reset", st_wait, 0);
        rst = 0; ld_req = 0; st_req = 0;
        model_reset();
        step(1, 1, 0, 0, 1, 0, "R3 after reset");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule